// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches ten asynchronous interrupt request pins and keeps one request flag per pin for a small processor's interrupt controller. Each pin passes through a two-stage synchronizer. The synchronized value is then looked at only on clock cycles where the machine-cycle strobe input is high. An edge is recognised by comparing two such samples that follow one another.

The channels come in three kinds, fixed by their index. Channels 0 and 1 trigger either on a low level or on a falling edge. Channels 2, 3, 7, 8 and 9 trigger on an edge whose direction is set by a per-channel mode bit. Channels 4, 5 and 6 trigger only on a rising edge.

The controller clears a flag through the per-channel acknowledge when it takes that channel's vector. Software can overwrite any flag through a per-channel write enable with write data. Arbitration between channels and vectoring are handled elsewhere.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is low, and on the first cycle after it, every bit of `flag_o` is 0.
- R2: On channels 0 and 1 with `mode_i` bit = 0 (level mode), every strobe cycle loads the flag with the inverse of the synchronized pin sample: 1 when the pin is low, 0 when it is high. This strobe update takes priority over a software write and over an acknowledge.
- R3: On channels 0 and 1 with `mode_i` bit = 1, the flag is set when one strobe sample is high and the next strobe sample is low.
- R4: On channels 2, 3, 7, 8 and 9, `mode_i` bit = 0 selects falling-edge detection (sample high, then low) and `mode_i` bit = 1 selects rising-edge detection (sample low, then high). An edge in the other direction leaves the flag unchanged.
- R5: Channels 4, 5 and 6 set their flag only on a rising edge between two strobe samples, whatever the value of their `mode_i` bit.
- R6: A pin is seen only through its synchronized value on strobe cycles. A pulse that is over before the next strobe sample does not set a flag. A flag never changes in a cycle that has no strobe, no write and no acknowledge.
- R7: An acknowledge on a cycle with no strobe and no write clears the flag on the next clock. In level mode the next strobe with the pin still low sets the flag again.
- R8: An edge detected in the same cycle as an acknowledge or a software write leaves the flag at 1.
- R9: With `sw_we_i` bit high and no strobe, the flag takes the `sw_wdata_i` bit on the next clock. The write wins over an acknowledge in the same cycle.
- R10: After reset no edge is reported until two successive strobe samples of fully synchronized pin values have been taken. A pin held at a constant level through and after reset never sets an edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_strobe_i | input | 1 | One-cycle pulse marking the sampling point of each machine cycle |
| pin_i | input | 10 | Asynchronous interrupt request pins |
| mode_i | input | 10 | Per-channel trigger mode bit, meaning depends on channel kind |
| ack_i | input | 10 | Vector-taken acknowledge, clears the flag |
| sw_we_i | input | 10 | Software write enable per flag |
| sw_wdata_i | input | 10 | Software write data per flag |
| flag_o | output | 10 | Latched interrupt request flags |

## Verification
The assertions check on every cycle four rules about the flags. Flags are clear in reset. A flag holds when no strobe, write or acknowledge is present. A lone acknowledge clears the flag. A write without a strobe lands exactly. Which way an edge is detected for each channel kind and mode cannot be seen at the ports on a single cycle. The same holds for ignoring pulses shorter than a machine cycle, for the rule that an edge wins over an acknowledge, and for the absence of a false edge after reset. These are shown only by the bench's directed scenarios and by its cycle-accurate reference model running under random pin activity.

// File: rtl/eid_pkg.sv
// Shared types for the external interrupt detector.
// Assumes channel kinds are fixed by channel index, as the interrupt
// controller decodes them.
package eid_pkg;

    typedef enum logic [1:0] {
        KIND_LVL_FALL = 2'd0,   // low level or falling edge
        KIND_SEL_EDGE = 2'd1,   // falling or rising edge, chosen by mode bit
        KIND_RISE     = 2'd2    // rising edge only
    } chan_kind_e;

    // Map a channel index to its trigger kind.
    function automatic chan_kind_e kind_of(input int unsigned ch);
        if (ch < 2)
            return KIND_LVL_FALL;
        else if (ch >= 4 && ch <= 6)
            return KIND_RISE;
        else
            return KIND_SEL_EDGE;
    endfunction

endpackage

// File: rtl/eid_sync.sv
// Multi-stage synchronizer, one independent chain per input bit.
// Assumes STAGES >= 2. Chains reset to 1; the sampler ignores its output
// until the chains have been refilled after reset.
module eid_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the asynchronous pin into the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain_q <= '1;
            else
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/eid_sampler.sv
// Takes one sample of each synchronized pin per machine cycle and reports
// edges between consecutive samples, qualified with the strobe.
// Assumes PRIME equals the synchronizer depth, so that no sample taken
// before the chains refill can form an edge.
module eid_sampler #(
    parameter int unsigned W     = 10,
    parameter int unsigned PRIME = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] samp_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    localparam int unsigned CW = $clog2(PRIME + 1);

    logic [CW-1:0] fill_q;
    logic          primed;
    logic          valid_q;
    logic [W-1:0]  prev_q;

    assign primed = (fill_q == CW'(PRIME));

    // Count clocks since reset until the synchronizer holds real pin values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (!primed)
            fill_q <= fill_q + 1'b1;
    end

    // Keep the previous machine-cycle sample and whether it is trustworthy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '1;
            valid_q <= 1'b0;
        end else if (strobe_i) begin
            prev_q  <= samp_i;
            valid_q <= primed;
        end
    end

    assign rise_o = {W{strobe_i & valid_q}} & ~prev_q &  samp_i;
    assign fall_o = {W{strobe_i & valid_q}} &  prev_q & ~samp_i;

endmodule

// File: rtl/eid_flag.sv
// One request flag. KIND selects how the mode bit is read.
// Priority: level-mode strobe update, then edge set, then software write,
// then acknowledge clear.
module eid_flag #(
    parameter eid_pkg::chan_kind_e KIND = eid_pkg::KIND_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic samp_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic mode_i,
    input  logic ack_i,
    input  logic we_i,
    input  logic wdata_i,
    output logic flag_o
);

    logic level_mode;
    logic hit;
    logic flag_d;

    // Decode the trigger condition for this channel kind.
    always_comb begin
        level_mode = 1'b0;
        hit        = 1'b0;
        case (KIND)
            eid_pkg::KIND_LVL_FALL: begin
                level_mode = ~mode_i;
                hit        = mode_i & fall_i;
            end
            eid_pkg::KIND_SEL_EDGE: hit = mode_i ? rise_i : fall_i;
            default:                hit = rise_i;
        endcase
    end

    // Resolve the next flag value by priority.
    always_comb begin
        if (level_mode && strobe_i)
            flag_d = ~samp_i;
        else if (hit)
            flag_d = 1'b1;
        else if (we_i)
            flag_d = wdata_i;
        else if (ack_i)
            flag_d = 1'b0;
        else
            flag_d = flag_o;
    end

    // Hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else
            flag_o <= flag_d;
    end

endmodule

// File: rtl/ext_irq_detect.sv
// External interrupt request detector: synchronizes the pins, samples once
// per machine cycle and keeps one request flag per channel. The channel
// kind comes from eid_pkg::kind_of. Assumes mc_strobe_i is a single-cycle
// pulse per machine cycle.
module ext_irq_detect #(
    parameter int unsigned NCH         = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mc_strobe_i,
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] mode_i,
    input  logic [NCH-1:0] ack_i,
    input  logic [NCH-1:0] sw_we_i,
    input  logic [NCH-1:0] sw_wdata_i,
    output logic [NCH-1:0] flag_o
);

    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] fall;

    eid_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    eid_sampler #(.W(NCH), .PRIME(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (mc_strobe_i),
        .samp_i   (pin_sync),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam eid_pkg::chan_kind_e K = eid_pkg::kind_of(i);

        eid_flag #(.KIND(K)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (mc_strobe_i),
            .samp_i   (pin_sync[i]),
            .rise_i   (rise[i]),
            .fall_i   (fall[i]),
            .mode_i   (mode_i[i]),
            .ack_i    (ack_i[i]),
            .we_i     (sw_we_i[i]),
            .wdata_i  (sw_wdata_i[i]),
            .flag_o   (flag_o[i])
        );
    end

endmodule

// File: rtl/eid_checker.sv
// Cycle-level checks on the request flags, bound to ext_irq_detect.
module eid_checker #(
    parameter int unsigned NCH = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mc_strobe_i,
    input logic [NCH-1:0] ack_i,
    input logic [NCH-1:0] sw_we_i,
    input logic [NCH-1:0] sw_wdata_i,
    input logic [NCH-1:0] flag_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_o == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mc_strobe_i && !sw_we_i[i] && !ack_i[i]) |=> $stable(flag_o[i]));

        assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[i] && !mc_strobe_i && !sw_we_i[i]) |=> !flag_o[i]);

        assert_sw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_we_i[i] && !mc_strobe_i) |=> (flag_o[i] == $past(sw_wdata_i[i])));
    end

endmodule

bind ext_irq_detect eid_checker #(.NCH(NCH)) u_eid_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mc_strobe_i (mc_strobe_i),
    .ack_i       (ack_i),
    .sw_we_i     (sw_we_i),
    .sw_wdata_i  (sw_wdata_i),
    .flag_o      (flag_o)
);

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;

    localparam int NCH = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           strobe = 1'b0;
    logic [NCH-1:0] pin = '0;
    logic [NCH-1:0] mode = '0;
    logic [NCH-1:0] ack = '0;
    logic [NCH-1:0] we = '0;
    logic [NCH-1:0] wdata = '0;
    logic [NCH-1:0] flag;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit model_on = 1'b0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_detect i_ext_irq_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_strobe_i (strobe),
        .pin_i       (pin),
        .mode_i      (mode),
        .ack_i       (ack),
        .sw_we_i     (we),
        .sw_wdata_i  (wdata),
        .flag_o      (flag)
    );

    // Channel classes from the requirements.
    function automatic bit is_lf(int ch);   return ch < 2;              endfunction
    function automatic bit is_rise(int ch); return ch >= 4 && ch <= 6;  endfunction

    function automatic string req_of(int ch, bit md);
        if (is_lf(ch))   return md ? "R3" : "R2";
        if (is_rise(ch)) return "R5";
        return "R4";
    endfunction

    // Reference model, built from the requirements.
    logic [NCH-1:0] m_s1, m_s2, m_prev, m_flag;
    logic           m_valid;
    int             m_fill;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_prev <= '1;
            m_valid <= 1'b0; m_fill <= 0; m_flag <= '0;
        end else begin
            m_s1 <= pin;
            m_s2 <= m_s1;
            if (m_fill < 2) m_fill <= m_fill + 1;
            if (strobe) begin
                m_prev  <= m_s2;
                m_valid <= (m_fill >= 2);
            end
            for (int c = 0; c < NCH; c++) begin
                bit r, f, hit, lvl;
                r   = strobe && m_valid && !m_prev[c] &&  m_s2[c];
                f   = strobe && m_valid &&  m_prev[c] && !m_s2[c];
                lvl = is_lf(c) && !mode[c];
                if (is_lf(c))        hit = mode[c] && f;
                else if (is_rise(c)) hit = r;
                else                 hit = mode[c] ? r : f;
                if (lvl && strobe)   m_flag[c] <= !m_s2[c];
                else if (hit)        m_flag[c] <= 1'b1;
                else if (we[c])      m_flag[c] <= wdata[c];
                else if (ack[c])     m_flag[c] <= 1'b0;
            end
        end
    end

    // Compare against the model on every falling edge out of reset.
    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            n_checks++;
            if (flag !== m_flag) begin
                n_fails++;
                for (int c = 0; c < NCH; c++)
                    if (flag[c] !== m_flag[c])
                        $display("FAIL %s model ch%0d: got %b expected %b",
                                 req_of(c, mode[c]), c, flag[c], m_flag[c]);
            end
        end
    end

    task automatic check(string req, logic [NCH-1:0] got, logic [NCH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge and wait for the next one.
    task automatic cyc(bit st, logic [NCH-1:0] a, logic [NCH-1:0] w, logic [NCH-1:0] d);
        strobe = st; ack = a; we = w; wdata = d;
        @(negedge clk);
        strobe = 1'b0; ack = '0; we = '0; wdata = '0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(1'b0, '0, '0, '0);
    endtask

    // A full machine cycle: three idle clocks then one strobe clock.
    task automatic mcycle(int n);
        for (int k = 0; k < n; k++) begin
            idle(3);
            cyc(1'b1, '0, '0, '0);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    localparam logic [NCH-1:0] RISE_CH = 10'b00_0111_0000;
    localparam logic [NCH-1:0] SEL_CH  = 10'b11_1000_1100;
    localparam logic [NCH-1:0] LF_CH   = 10'b00_0000_0011;

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // R1: flags clear in reset and just after it.
        pin = '0; mode = LF_CH;
        repeat (4) @(negedge clk);
        check("R1", flag, '0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check("R1", flag, '0);

        // R10: pins held low since reset (against high-reset synchronizer).
        cyc(1'b1, '0, '0, '0);
        mcycle(4);
        check("R10", flag, '0);

        // R5 and R4: rising edge on every pin; rising modes on selectable channels.
        mode = LF_CH | (SEL_CH & 10'b10_0000_0100) | RISE_CH;
        pin = '1;
        mcycle(2);
        check("R5", flag & RISE_CH, RISE_CH);
        check("R4", flag & SEL_CH, 10'b10_0000_0100);
        check("R3", flag & LF_CH, '0);

        // R7: acknowledge clears edge flags.
        cyc(1'b0, '1, '0, '0);
        check("R7", flag, '0);

        // R3, R4, R5: falling edge on every pin.
        pin = '0;
        mcycle(2);
        check("R3", flag & LF_CH, LF_CH);
        check("R4", flag & SEL_CH, SEL_CH & ~10'b10_0000_0100);
        check("R5", flag & RISE_CH, '0);

        // R9: software write, with an acknowledge that loses to it.
        cyc(1'b0, '1, '1, 10'b10_1010_0101);
        check("R9", flag, 10'b10_1010_0101);
        cyc(1'b0, '0, '1, '0);
        check("R9", flag, '0);

        // R2 and R7: level mode on channels 0 and 1 with pins low.
        mode = RISE_CH;
        mcycle(1);
        check("R2", flag & LF_CH, LF_CH);
        cyc(1'b0, LF_CH, '0, '0);
        check("R7", flag & LF_CH, '0);
        mcycle(1);
        check("R7", flag & LF_CH, LF_CH);
        pin = '1;
        mcycle(2);
        check("R2", flag & LF_CH, '0);

        // R6: one-clock pulse between strobes is missed.
        mode = '1;
        pin = '0;
        mcycle(2);
        cyc(1'b0, '1, '0, '0);
        pin = '1;
        @(negedge clk);
        pin = '0;
        idle(5);
        cyc(1'b1, '0, '0, '0);
        mcycle(1);
        check("R6", flag & (RISE_CH | SEL_CH), '0);

        // R8: rising edge sampled in the same cycle as acknowledge and write 0.
        pin = '1;
        idle(3);
        cyc(1'b1, RISE_CH | SEL_CH, RISE_CH | SEL_CH, '0);
        check("R8", flag & (RISE_CH | SEL_CH), RISE_CH | SEL_CH);

        // Random phase: strobe every four clocks, held and glitching pins.
        for (int t = 0; t < 40000; t++) begin
            bit st;
            st = (t % 4) == 3;
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 9) == 0) pin[c] = ~pin[c];
            end
            if ($urandom_range(0, 499) == 0) mode = NCH'($urandom);
            cyc(st,
                NCH'($urandom) & NCH'($urandom) & NCH'($urandom),
                NCH'($urandom) & NCH'($urandom) & NCH'($urandom) & NCH'($urandom),
                NCH'($urandom));
        end

        finish_up();
    end

endmodule